// File: doc/BRIEF.md
# I2C Slave Address Filter with Group Mask

This block handles the address phase of an I2C slave. It samples the bus lines SCL and SDA after a synchroniser and detects START, repeated START and STOP conditions. It then shifts in the address byte or bytes and compares them with a programmed own address. A 5-bit mask makes selected address bits don't-care, so a single slave answers a whole group of addresses. The mask applies to different address bits in 7-bit mode and in 10-bit mode.

When an address matches, the block pulls SDA low in the ninth clock through an open-drain enable. It also raises a one-cycle interrupt and keeps the received address byte in a buffer. Firmware reads that buffer to learn which of the grouped addresses was called. When an address does not match, SDA stays released and the block waits for the next START. The data phase after the address is handled elsewhere.

Top module: `i2c_addr_filter`

## Requirements
- R1: SDA falling while SCL is high (START) begins address reception at bit 0, also in the middle of a byte (repeated START). SDA rising while SCL is high (STOP) aborts any byte in progress, releases SDA and returns the block to idle.
- R2: With `mode_10b` = 0, bits 7:1 of the received byte are compared with `own_lo[7:1]`, and bit 0 is the R/W bit. For n from 1 to 5, `addr_mask[n]` = 1 makes byte bit n a don't-care. Bits 7:6 are always compared. Example: own 0xA0 with mask 5'b00111 accepts 0xA0, 0xA2 and so on up to 0xAE, in each case with either R/W value.
- R3: With `mode_10b` = 1, the first byte is accepted only if its bits 7:3 equal 11110 and its bits 2:1 equal `own_hi`. Its bit 0 is the R/W bit. An accepted first byte is acknowledged but raises no interrupt.
- R4: In 10-bit mode, the second byte is compared with all 8 bits of `own_lo`. `addr_mask[5:2]` masks byte bits 5:2 one for one. `addr_mask[1]` masks byte bits 1 and 0 together. Bits 7:6 are always compared. Example: own low 0xA0 with mask 5'b00111 accepts 0xA0 through 0xAF.
- R5: On an accepted byte, `sda_oe` rises after the SCL falling edge that ends bit 8, holds through the ninth SCL high period and drops after the ninth SCL falling edge. On any other byte, `sda_oe` stays 0.
- R6: `match_irq` is a single-cycle pulse, issued once for each complete address match: a 7-bit byte, or a 10-bit low byte that follows an accepted first byte.
- R7: On each complete match, `rx_buf` loads the matched byte (the 7-bit byte including R/W, or the 10-bit low byte). `rw_flag` loads the R/W bit (bit 0 of the 7-bit byte or of the 10-bit first byte). Both hold their values until the next match.
- R8: After a rejected byte, the block ignores all further bus activity until the next START.
- R9: Reset (synchronous, active high) clears `sda_oe`, `match_irq`, `rx_buf` and `rw_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line as seen at the pad |
| sda_in | input | 1 | SDA line as seen at the pad (wired-AND bus value) |
| mode_10b | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| own_lo | input | 8 | Own address: bits 7:1 in 7-bit mode, low byte in 10-bit mode |
| own_hi | input | 2 | Two high address bits for 10-bit mode |
| addr_mask | input | 5 | Mask bits indexed 5 down to 1; 1 makes the mapped bits don't-care |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| match_irq | output | 1 | One-cycle pulse for each complete address match |
| rx_buf | output | 8 | Last matched address byte |
| rw_flag | output | 1 | R/W bit of the last match |

## Verification
The bench sends bit-banged frames with an all-zero mask, which shows that single bits are compared exactly. It also uses a partial mask and sweeps every byte of the accepted group, which separates masked bit positions from compared ones. A full mask is paired with flips in bits 7:6, which shows that the top bits can never be masked. In 10-bit mode, mask 5'b00001 tells whether bits 1 and 0 are masked as a pair or only bit 1 is masked, and a first byte with the wrong high bits checks the header gate together with the idle state that follows a rejection. Repeated STARTs after a rejected byte and in the middle of a byte, and a STOP in the middle of a byte, exercise the bus-condition paths.

// File: rtl/i2c_amf_pkg.sv
`timescale 1ns/1ps
package i2c_amf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_DECIDE = 2'd2,
    ST_ACK    = 2'd3
  } amf_state_t;

  localparam logic [4:0] HDR_TAG = 5'b11110;
endpackage

// File: rtl/amf_sync.sv
`timescale 1ns/1ps
module amf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 1) begin : g_one
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= 1'b1;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{1'b1}};
        else     chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/amf_bus_cond.sv
`timescale 1ns/1ps
module amf_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_d;
  assign scl_fall  = ~scl & scl_d;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl & scl_d & sda_d & ~sda;
  assign stop_det  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/amf_addr_cmp.sv
`timescale 1ns/1ps
module amf_addr_cmp
  import i2c_amf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              mode_10b,
  input  logic              hdr_stage,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [BYTE_W-1:0] own_lo,
  input  logic [1:0]        own_hi,
  input  logic [5:1]        addr_mask,
  output logic              hit
);
  localparam int TOP_W = BYTE_W - 6;

  logic [BYTE_W-1:0] care7, care10, diff;

  // 7-bit: bit 0 is R/W, mask bit n covers byte bit n
  assign care7  = ~{{TOP_W{1'b0}}, addr_mask[5:1], 1'b1};
  // 10-bit low byte: mask bit 1 covers byte bits 1:0 together
  assign care10 = ~{{TOP_W{1'b0}}, addr_mask[5:2], addr_mask[1], addr_mask[1]};
  assign diff   = rx_byte ^ own_lo;

  always_comb begin
    if (!mode_10b)
      hit = ((diff & care7) == '0);
    else if (hdr_stage)
      hit = (rx_byte[7:3] == HDR_TAG) && (rx_byte[2:1] == own_hi);
    else
      hit = ((diff & care10) == '0);
  end
endmodule

// File: rtl/i2c_addr_filter.sv
`timescale 1ns/1ps
module i2c_addr_filter
  import i2c_amf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              mode_10b,
  input  logic [BYTE_W-1:0] own_lo,
  input  logic [1:0]        own_hi,
  input  logic [5:1]        addr_mask,
  output logic              sda_oe,
  output logic              match_irq,
  output logic [BYTE_W-1:0] rx_buf,
  output logic              rw_flag
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic hit;

  amf_state_t        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic              hdr_stage;
  logic              hdr_rw;

  amf_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (.clk(clk), .rst(rst), .d(scl_in), .q(scl_s));
  amf_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (.clk(clk), .rst(rst), .d(sda_in), .q(sda_s));

  amf_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  amf_addr_cmp #(.BYTE_W(BYTE_W)) u_cmp (
    .mode_10b(mode_10b), .hdr_stage(hdr_stage), .rx_byte(shreg),
    .own_lo(own_lo), .own_hi(own_hi), .addr_mask(addr_mask), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      hdr_stage <= 1'b0;
      hdr_rw    <= 1'b0;
      sda_oe    <= 1'b0;
      match_irq <= 1'b0;
      rx_buf    <= '0;
      rw_flag   <= 1'b0;
    end else begin
      match_irq <= 1'b0;
      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state     <= ST_SHIFT;
        bitcnt    <= '0;
        hdr_stage <= mode_10b;
        sda_oe    <= 1'b0;
      end else begin
        case (state)
          ST_SHIFT: if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) state <= ST_DECIDE;
          end
          ST_DECIDE: if (scl_fall) begin
            if (hit) begin
              sda_oe <= 1'b1;
              state  <= ST_ACK;
              if (hdr_stage) begin
                hdr_rw <= shreg[0];
              end else begin
                match_irq <= 1'b1;
                rx_buf    <= shreg;
                rw_flag   <= mode_10b ? hdr_rw : shreg[0];
              end
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            if (hdr_stage) begin
              state     <= ST_SHIFT;
              bitcnt    <= '0;
              hdr_stage <= 1'b0;
            end else begin
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    match_irq |=> !match_irq); // R6
  AST_IRQ_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    match_irq |-> sda_oe); // R6
  AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall)); // R5
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && state == ST_IDLE)); // R1
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !match_irq |-> (rx_buf == $past(rx_buf) && rw_flag == $past(rw_flag))); // R7
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= CNT_W'(BYTE_W)); // R1
endmodule

// File: tb/i2c_addr_filter_test.sv
`timescale 1ns/1ps
module i2c_addr_filter_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       mode_10b = 1'b0;
  logic [7:0] own_lo = 8'h00;
  logic [1:0] own_hi = 2'b00;
  logic [5:1] addr_mask = 5'b00000;
  logic       sda_oe, match_irq, rw_flag;
  logic [7:0] rx_buf;
  wire        sda_bus = sda_m & ~sda_oe;

  i2c_addr_filter uut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_bus),
    .mode_10b(mode_10b), .own_lo(own_lo), .own_hi(own_hi), .addr_mask(addr_mask),
    .sda_oe(sda_oe), .match_irq(match_irq), .rx_buf(rx_buf), .rw_flag(rw_flag)
  );

  int vectors = 0, fails = 0, irq_seen = 0;
  bit ack_win = 1'b0, done = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock model: ACK enable only inside an ACK window (R5)
  always @(negedge clk) if (!rst && !done) begin
    if (match_irq) irq_seen++;
    if (!ack_win) chk(!sda_oe, "R5", "sda_oe outside ack window", int'(sda_oe), 0);
  end

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q);
      if (i == 0) ack_win = 1'b1;
      scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = sda_oe; wq(Q); scl_m = 1'b0; wq(Q);
    ack_win = 1'b0;
    chk(!sda_oe, "R5", "sda_oe released after ninth clock", int'(sda_oe), 0);
  endtask

  function automatic bit exp7(logic [7:0] b);
    for (int i = 1; i < 8; i++) begin
      if (i <= 5) begin if (addr_mask[i]) continue; end
      if (b[i] != own_lo[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit exp10lo(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (i <= 5) begin if (addr_mask[(i < 2) ? 1 : i]) continue; end
      if (b[i] != own_lo[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic frame7(logic [7:0] b);
    bit ack, e;
    e = exp7(b);
    irq_seen = 0;
    bus_start; send_byte(b, ack);
    chk(ack == e, "R2", "7-bit ack", int'(ack), int'(e));
    chk(irq_seen == (e ? 1 : 0), "R6", "7-bit irq count", irq_seen, e ? 1 : 0);
    if (e) begin
      chk(rx_buf == b, "R7", "buffer byte", rx_buf, b);
      chk(rw_flag == b[0], "R7", "rw flag", int'(rw_flag), int'(b[0]));
    end
    bus_stop;
  endtask

  task automatic frame10(logic [1:0] hi, logic rw, logic [7:0] lo);
    bit ack, eh, el;
    eh = (hi == own_hi);
    el = exp10lo(lo);
    irq_seen = 0;
    bus_start; send_byte({5'b11110, hi, rw}, ack);
    chk(ack == eh, "R3", "10-bit header ack", int'(ack), int'(eh));
    chk(irq_seen == 0, "R6", "no irq on header", irq_seen, 0);
    send_byte(lo, ack);
    if (eh) begin
      chk(ack == el, "R4", "10-bit low ack", int'(ack), int'(el));
      chk(irq_seen == (el ? 1 : 0), "R6", "10-bit irq count", irq_seen, el ? 1 : 0);
      if (el) begin
        chk(rx_buf == lo, "R7", "buffer low byte", rx_buf, lo);
        chk(rw_flag == rw, "R7", "rw from header", int'(rw_flag), int'(rw));
      end
    end else begin
      chk(!ack, "R8", "ignored after rejected header", int'(ack), 0);
      chk(irq_seen == 0, "R8", "no irq after rejected header", irq_seen, 0);
    end
    bus_stop;
  endtask

  initial begin
    bit ack;
    logic [7:0] keep;
    wq(6);
    chk(!sda_oe && !match_irq && rx_buf == 8'h00 && !rw_flag, "R9", "reset state",
        {sda_oe, match_irq, rw_flag}, 0);
    rst = 1'b0; wq(4);
    chk(rx_buf == 8'h00, "R9", "buffer after reset", rx_buf, 0);

    // 7-bit, exact compare
    own_lo = 8'hA0; addr_mask = 5'b00000;
    frame7(8'hA0); frame7(8'hA1); frame7(8'hA2); frame7(8'h20);
    // 7-bit, grouped
    addr_mask = 5'b00111;
    for (int k = 0; k < 16; k++) frame7(8'hA0 + 8'(k));
    frame7(8'hB0); frame7(8'h20); frame7(8'hE0);
    // full mask, top bits still compared
    addr_mask = 5'b11111;
    frame7(8'h80); frame7(8'hBF); frame7(8'hE0); frame7(8'h40);

    // buffer holds across a rejected frame (R7)
    addr_mask = 5'b00000;
    frame7(8'hA1); keep = rx_buf;
    frame7(8'h52);
    chk(rx_buf == keep, "R7", "buffer kept after reject", rx_buf, keep);

    // repeated START after rejected byte (R1, R8)
    irq_seen = 0;
    bus_start; send_byte(8'h40, ack);
    chk(!ack, "R8", "reject before repeated start", int'(ack), 0);
    send_byte(8'hA0, ack);
    chk(!ack, "R8", "ignored until START", int'(ack), 0);
    bus_start; send_byte(8'hA0, ack);
    chk(ack, "R1", "ack after repeated START", int'(ack), 1);
    chk(irq_seen == 1, "R1", "irq after repeated START", irq_seen, 1);
    // repeated START mid-byte
    irq_seen = 0;
    bus_start; send_bits(8'hFF, 3); bus_start; send_byte(8'hA0, ack);
    chk(ack, "R1", "ack after mid-byte START", int'(ack), 1);
    chk(irq_seen == 1, "R1", "irq after mid-byte START", irq_seen, 1);
    bus_stop;
    // STOP mid-byte aborts
    irq_seen = 0;
    bus_start; send_bits(8'hA0, 4); bus_stop;
    scl_m = 1'b0; wq(Q);
    send_byte(8'hA0, ack);
    chk(!ack, "R1", "no ack after STOP abort", int'(ack), 0);
    chk(irq_seen == 0, "R1", "no irq after STOP abort", irq_seen, 0);
    bus_stop;

    // 10-bit mode
    mode_10b = 1'b1; own_hi = 2'b10; own_lo = 8'hA0; addr_mask = 5'b00111;
    for (int k = 0; k < 16; k++) frame10(2'b10, k[0], 8'hA0 + 8'(k));
    frame10(2'b10, 1'b0, 8'hB0); frame10(2'b10, 1'b0, 8'h20);
    frame10(2'b01, 1'b0, 8'hA0); frame10(2'b11, 1'b1, 8'hA0);
    addr_mask = 5'b00001;
    frame10(2'b10, 1'b0, 8'hA3); frame10(2'b10, 1'b1, 8'hA1);
    frame10(2'b10, 1'b0, 8'hA4);
    addr_mask = 5'b00000;
    frame10(2'b10, 1'b1, 8'hA0); frame10(2'b10, 1'b0, 8'hA1);
    addr_mask = 5'b11111;
    frame10(2'b10, 1'b0, 8'hBF); frame10(2'b10, 1'b0, 8'h60);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule